// File: doc/BRIEF.md
# Sampled PI Loop Filter with Phase Oscillator

This block is the arithmetic heart of a sampled second-order phase tracking loop. On every accepted sample it takes a signed phase-error word from an external detector. A proportional-plus-integral filter turns that error into a control word. The control word, added to a fixed nominal step, advances a phase accumulator that wraps modulo one full turn. A sine/cosine table turns the accumulated phase into a quadrature pair that the detector can use as the real and imaginary parts of a local complex exponential.

Both gains and the nominal step are runtime inputs. The detector and any translation from bandwidth or damping into gains stay outside. The phase reported for a sample is the accumulator value before that sample's control word is applied. This gives the loop exactly one sample of delay in the oscillator path, and the integrator's pole at z = 1 sits in series with it. A 16-bit phase word covers 2π. Gains are signed Q1.15.

Top module: `pi_nco_loop`

## Requirements
- R1: While rst_ni is low and after its release, valid_o, phase_o, ctrl_o, cos_o and sin_o are zero. The phase accumulator and the integrator start from zero, so the first sample reports phase 0.
- R2: For each sample, ctrl_o = rnd(kp·err) + s, where s is the integrator value after this sample's update. The update is s = s_prev + rnd(ki·err). The function rnd(x) is floor((x + 2^14) / 2^15), with kp and ki read as signed Q1.15.
- R3: The 24-bit integrator saturates at +8388607 and at −8388608. It never wraps.
- R4: phase_o reports the accumulator value before the sample is applied. The accumulator then advances by base_inc_i plus the low 16 bits of the control word, modulo 2^16.
- R5: cos_o and sin_o equal 32767·cos and 32767·sin of 2π·k/1024, within 1 LSB. Here k is bits 15:6 of the reported phase.
- R6: valid_o is high in exactly the cycle after each cycle with en_i high, and low otherwise.
- R7: In a cycle with en_i low, the integrator, the accumulator and all data outputs hold their values, whatever err_i, kp_i, ki_i or base_inc_i carry.
- R8: Use kp = 4846 (0.1479), ki = 193 (0.0059) and base_inc = 6554 (2π/10), and drive the input phase as 6554·n + 32768 (a π step at sample 0). The wrapped error, input phase minus reported phase, then stays within ±128 (two table steps) from sample 100 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Sample strobe: err_i and the settings are taken this cycle |
| err_i | input | 16 | Signed phase error, full range = ±π |
| kp_i | input | 16 | Proportional gain, signed Q1.15 |
| ki_i | input | 16 | Integral gain, signed Q1.15 |
| base_inc_i | input | 16 | Nominal per-sample phase step |
| valid_o | output | 1 | Outputs below belong to the sample taken last cycle |
| phase_o | output | 16 | Phase estimate used for that sample |
| ctrl_o | output | 25 | Signed control word of that sample |
| cos_o | output | 16 | Signed in-phase table output |
| sin_o | output | 16 | Signed quadrature table output |

## Verification
A wrong integrator value shows on ctrl_o in the very sample where it arises. It reaches phase_o one sample later, because the control word only moves the accumulator for the next sample. A bad accumulator or a bad table entry appears on phase_o or on the quadrature pair in the cycle after the strobe. A bit-exact bench model of the same recurrence therefore catches any divergence within one or two samples. The closed-loop run also shows whether the pole and the delay combine into a loop that settles.

// File: rtl/pi_nco_pkg.sv
package pi_nco_pkg;

  // quarter-wave sine sample idx of 2^qbits per quarter turn, scaled to amp
  function automatic longint quarter_sine(input int idx, input int qbits, input int amp);
    longint x, x2, term, acc, res;
    x    = (longint'(idx) * 64'sd1686629713) >>> qbits;  // angle in Q30
    x2   = (x * x) >>> 30;
    term = x;
    acc  = x;
    for (int k = 1; k <= 6; k++) begin
      term = -(((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1)));
      acc  = acc + term;
    end
    res = (acc * longint'(amp) + (64'sd1 <<< 29)) >>> 30;
    if (res > longint'(amp)) res = longint'(amp);
    if (res < 0) res = 0;
    return res;
  endfunction

endpackage

// File: rtl/pi_filter.sv
module pi_filter #(
  parameter int ERR_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15,
  parameter int INT_W     = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic signed [GAIN_W-1:0] kp_i,
  input  logic signed [GAIN_W-1:0] ki_i,
  output logic signed [INT_W:0]   ctrl_o
);
  localparam int PROD_W = ERR_W + GAIN_W;
  localparam int SUM_W  = ((PROD_W > INT_W) ? PROD_W : INT_W) + 2;
  localparam logic signed [SUM_W-1:0] RND   = SUM_W'(64'sd1 <<< (GAIN_FRAC - 1));
  localparam logic signed [SUM_W-1:0] S_MAX = SUM_W'((64'sd1 <<< (INT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] S_MIN = SUM_W'(-(64'sd1 <<< (INT_W - 1)));

  logic signed [PROD_W-1:0] p_prod, i_prod;
  logic signed [SUM_W-1:0]  p_term, i_term, integ_ext, integ_sum, integ_sat;
  logic signed [INT_W-1:0]  integ_q, integ_d;

  assign p_prod = kp_i * err_i;
  assign i_prod = ki_i * err_i;

  // round half up, then drop the fraction
  assign p_term = (SUM_W'(p_prod) + RND) >>> GAIN_FRAC;
  assign i_term = (SUM_W'(i_prod) + RND) >>> GAIN_FRAC;

  assign integ_ext = SUM_W'(integ_q);
  assign integ_sum = integ_ext + i_term;

  always_comb begin
    if (integ_sum > S_MAX)      integ_sat = S_MAX;
    else if (integ_sum < S_MIN) integ_sat = S_MIN;
    else                        integ_sat = integ_sum;
  end

  assign integ_d = INT_W'(integ_sat);
  assign ctrl_o  = (INT_W + 1)'(p_term + integ_sat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   integ_q <= '0;
    else if (en_i) integ_q <= integ_d;
  end
endmodule

// File: rtl/phase_acc.sv
module phase_acc #(
  parameter int PH_W   = 16,
  parameter int CTRL_W = 25
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [PH_W-1:0]          base_inc_i,
  input  logic signed [CTRL_W-1:0] ctrl_i,
  output logic [PH_W-1:0]          phase_o
);
  logic [PH_W-1:0] step;

  // only the low bits matter: the word wraps modulo one turn
  assign step = base_inc_i + PH_W'(ctrl_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   phase_o <= '0;
    else if (en_i) phase_o <= phase_o + step;
  end
endmodule

// File: rtl/sincos_lut.sv
module sincos_lut
  import pi_nco_pkg::*;
#(
  parameter int AW    = 10,
  parameter int AMP_W = 16
) (
  input  logic [AW-1:0]           idx_i,
  output logic signed [AMP_W-1:0] cos_o,
  output logic signed [AMP_W-1:0] sin_o
);
  localparam int QW      = AW - 2;
  localparam int QN      = (1 << QW) + 1;
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

  logic [AMP_W-1:0] rom [QN];

  for (genvar g = 0; g < QN; g++) begin : g_rom
    localparam logic [AMP_W-1:0] VAL = AMP_W'(quarter_sine(g, QW, AMP_MAX));
    assign rom[g] = VAL;
  end

  logic [1:0]    quad_s, quad_c;
  logic [QW:0]   off, mir;
  logic [AMP_W-1:0] mag_s, mag_c;

  assign quad_s = idx_i[AW-1 -: 2];
  assign quad_c = quad_s + 2'd1;   // cos(x) = sin(x + quarter turn)
  assign off    = {1'b0, idx_i[QW-1:0]};
  assign mir    = (QW + 1)'(QN - 1) - off;

  always_comb begin
    mag_s = rom[quad_s[0] ? mir : off];
    mag_c = rom[quad_c[0] ? mir : off];
    sin_o = quad_s[1] ? -$signed(mag_s) : $signed(mag_s);
    cos_o = quad_c[1] ? -$signed(mag_c) : $signed(mag_c);
  end
endmodule

// File: rtl/pi_nco_loop.sv
module pi_nco_loop #(
  parameter int PH_W      = 16,
  parameter int ERR_W     = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 15,
  parameter int INT_W     = 24,
  parameter int LUT_AW    = 10,
  parameter int AMP_W     = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [ERR_W-1:0]  err_i,
  input  logic signed [GAIN_W-1:0] kp_i,
  input  logic signed [GAIN_W-1:0] ki_i,
  input  logic [PH_W-1:0]          base_inc_i,
  output logic                     valid_o,
  output logic [PH_W-1:0]          phase_o,
  output logic signed [INT_W:0]    ctrl_o,
  output logic signed [AMP_W-1:0]  cos_o,
  output logic signed [AMP_W-1:0]  sin_o
);
  logic signed [INT_W:0]   ctrl_w;
  logic [PH_W-1:0]         phase_w;
  logic [LUT_AW-1:0]       lut_idx;
  logic signed [AMP_W-1:0] cos_w, sin_w;

  pi_filter #(
    .ERR_W(ERR_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .INT_W(INT_W)
  ) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .err_i(err_i), .kp_i(kp_i), .ki_i(ki_i), .ctrl_o(ctrl_w)
  );

  phase_acc #(.PH_W(PH_W), .CTRL_W(INT_W + 1)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .base_inc_i(base_inc_i), .ctrl_i(ctrl_w), .phase_o(phase_w)
  );

  assign lut_idx = LUT_AW'(phase_w >> (PH_W - LUT_AW));

  sincos_lut #(.AW(LUT_AW), .AMP_W(AMP_W)) u_lut (
    .idx_i(lut_idx), .cos_o(cos_w), .sin_o(sin_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      phase_o <= '0;
      ctrl_o  <= '0;
      cos_o   <= '0;
      sin_o   <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        phase_o <= phase_w;
        ctrl_o  <= ctrl_w;
        cos_o   <= cos_w;
        sin_o   <= sin_w;
      end
    end
  end
endmodule

// File: rtl/pi_nco_loop_chk.sv
module pi_nco_loop_chk #(
  parameter int PH_W  = 16,
  parameter int INT_W = 24,
  parameter int AMP_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic [PH_W-1:0]         base_inc_i,
  input logic                    valid_o,
  input logic [PH_W-1:0]         phase_o,
  input logic signed [INT_W:0]   ctrl_o,
  input logic signed [AMP_W-1:0] cos_o,
  input logic signed [AMP_W-1:0] sin_o
);
  localparam longint AMP   = (64'sd1 <<< (AMP_W - 1)) - 1;
  localparam longint MAG_LO = AMP * AMP - 4 * AMP;
  localparam longint MAG_HI = AMP * AMP + 4 * AMP;

  logic [PH_W-1:0] ctrl_lo;
  longint          mag;
  assign ctrl_lo = PH_W'(ctrl_o);
  assign mag     = longint'(cos_o) * longint'(cos_o) + longint'(sin_o) * longint'(sin_o);

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> valid_o);  // R6

  AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);  // R6

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(phase_o) && $stable(ctrl_o) && $stable(cos_o) && $stable(sin_o)));  // R7

  AST_PHASE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_o) |=>
      (phase_o == PH_W'($past(phase_o) + $past(base_inc_i, 2) + $past(ctrl_lo))));  // R4

  AST_UNIT_CIRCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mag >= MAG_LO && mag <= MAG_HI));  // R5
endmodule

bind pi_nco_loop pi_nco_loop_chk #(.PH_W(PH_W), .INT_W(INT_W), .AMP_W(AMP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .base_inc_i(base_inc_i),
  .valid_o(valid_o), .phase_o(phase_o), .ctrl_o(ctrl_o), .cos_o(cos_o), .sin_o(sin_o)
);

// File: tb/tb_pi_nco_loop.sv
`timescale 1ns/1ps
module tb_pi_nco_loop;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               en_i = 1'b0;
  logic signed [15:0] err_i = '0;
  logic signed [15:0] kp_i = '0;
  logic signed [15:0] ki_i = '0;
  logic [15:0]        base_inc_i = '0;
  logic               valid_o;
  logic [15:0]        phase_o;
  logic signed [24:0] ctrl_o;
  logic signed [15:0] cos_o, sin_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  longint m_s, m_ph;
  logic [31:0] rs = 32'h1234_5678;

  always #10 clk_i = ~clk_i;  // 50 MHz

  pi_nco_loop dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .err_i(err_i), .kp_i(kp_i),
    .ki_i(ki_i), .base_inc_i(base_inc_i), .valid_o(valid_o), .phase_o(phase_o),
    .ctrl_o(ctrl_o), .cos_o(cos_o), .sin_o(sin_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_tol(input string tag, input longint act, input longint exp);
    checks++;
    if (act > exp + 1 || act < exp - 1) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint tbl_exp(input longint ph, input bit want_sin);
    real a, r;
    a = 2.0 * 3.14159265358979 * real'(ph >>> 6) / 1024.0;
    r = 32767.0 * (want_sin ? $sin(a) : $cos(a));
    return (r >= 0.0) ? longint'($rtoi(r + 0.5)) : -longint'($rtoi(-r + 0.5));
  endfunction

  function automatic logic [31:0] nxt_rand(input logic [31:0] v);
    logic [31:0] x;
    x = v ^ (v << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    en_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    m_s = 0;
    m_ph = 0;
  endtask

  task automatic run_sample(input string tag, input longint e, input longint kp,
                            input longint ki, input longint base);
    longint pr, it, v, eph;
    err_i = 16'(e); kp_i = 16'(kp); ki_i = 16'(ki); base_inc_i = 16'(base);
    en_i = 1'b1;
    eph = m_ph;
    pr = (kp * e + 16384) >>> 15;
    it = (ki * e + 16384) >>> 15;
    m_s = m_s + it;
    if (m_s > 8388607) m_s = 8388607;
    if (m_s < -8388608) m_s = -8388608;
    v = pr + m_s;
    m_ph = (m_ph + base + v) & 65535;
    @(posedge clk_i);
    @(negedge clk_i);
    chk({tag, " R6 valid"}, longint'(valid_o), 1);
    chk({tag, " R4 phase"}, longint'(phase_o), eph);
    chk({tag, " R2 ctrl"}, longint'(ctrl_o), v);
    chk_tol({tag, " R5 cos"}, longint'(cos_o), tbl_exp(eph, 1'b0));
    chk_tol({tag, " R5 sin"}, longint'(sin_o), tbl_exp(eph, 1'b1));
  endtask

  initial begin
    longint held_ph, held_ctrl, th, d, e;
    do_reset();
    chk("R1 reset valid", longint'(valid_o), 0);
    chk("R1 reset phase", longint'(phase_o), 0);
    chk("R1 reset ctrl", longint'(ctrl_o), 0);
    chk("R1 reset cos", longint'(cos_o), 0);
    chk("R1 reset sin", longint'(sin_o), 0);

    // open loop: every table index once
    for (int i = 0; i < 1024; i++) run_sample(i == 0 ? "R1 first" : "sweep", 0, 0, 0, 64);

    // idle cycles with changing inputs
    run_sample("R7 prep", 500, 9000, 3000, 777);
    en_i = 1'b0;
    held_ph = longint'(phase_o);
    held_ctrl = longint'(ctrl_o);
    for (int i = 0; i < 4; i++) begin
      err_i = 16'(i * 1111 - 3000); kp_i = 16'(i * 4000); ki_i = 16'(20000 - i * 999);
      base_inc_i = 16'(i * 5000 + 13);
      @(posedge clk_i);
      @(negedge clk_i);
      chk("R6 idle valid", longint'(valid_o), 0);
      chk("R7 idle phase", longint'(phase_o), held_ph);
      chk("R7 idle ctrl", longint'(ctrl_o), held_ctrl);
    end
    run_sample("R7 resume", -700, 12000, -4000, 321);

    // mixed patterns including negative gains
    do_reset();
    for (int i = 0; i < 400; i++) begin
      longint re, rk, ri, rb;
      rs = nxt_rand(rs); re = longint'($signed(rs[15:0]));
      rk = longint'($signed(rs[31:16]));
      rs = nxt_rand(rs); ri = longint'($signed(rs[15:0]) >>> 3);
      rb = longint'(rs[31:16]);
      run_sample("R2 mixed", re, rk, ri, rb);
    end

    // saturation both ways
    do_reset();
    for (int i = 0; i < 300; i++) run_sample("R3 up", 32767, 0, 32767, 100);
    chk("R3 positive limit", longint'(ctrl_o), 8388607);
    for (int i = 0; i < 560; i++) run_sample("R3 down", -32768, 0, 32767, 100);
    chk("R3 negative limit", longint'(ctrl_o), -8388608);

    // closed loop with a half-turn step
    do_reset();
    for (int n = 0; n < 200; n++) begin
      th = (6554 * longint'(n) + 32768) & 65535;
      d = (th - m_ph) & 65535;
      e = (d >= 32768) ? d - 65536 : d;
      if (n >= 100) begin
        checks++;
        if (e > 128 || e < -128) begin
          errors++;
          $display("FAIL R8 settle sample %0d actual %0d expected within 128", n, e);
        end
      end
      run_sample("R8 loop", e, 4846, 193, 6554);
    end
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R6 final idle", longint'(valid_o), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule